// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog timer that sits on a plain 32-bit register bus. A free-running timebase counter advances on every clock, and software can read it to confirm that the clock is alive. A separate expiry counter of `INTERVAL_LOG2` bits runs only while the watchdog is armed. Arming takes two keys held in two different registers, so a single stray write cannot start or stop it.

Each time the expiry counter wraps, which happens every 2^`INTERVAL_LOG2` clocks, the watchdog sees an expiry. The first expiry only sets a state flag, and that flag drives the interrupt line. If the flag is still set at the following expiry, the block issues a one-clock reset pulse and latches a reset-status flag. Software keeps the system alive by writing ones to both flag bits. That write clears both flags and restarts the expiry counter. A build option, `ENABLE_ONCE`, makes arming permanent until the next hardware reset.

Top module: `wdog_top`

Register words (byte offsets): control word A at 0x0, control word B at 0x4, timebase at 0x8. Control word A fields: bit 3 reset-status flag, bit 2 state flag, bit 1 key A, bit 0 a read-only copy of key B. Control word B: bit 0 key B.

## Requirements
- R1: After reset, control words A and B read 0, the interrupt is low and the reset pulse is low.
- R2: The timebase word at offset 0x8 increases by exactly one on every clock after reset.
- R3: The expiry counter runs only while key A (word A bit 1) and key B (word B bit 0) are both 1. Key A alone never produces an expiry. Word A bit 0 reads back key B.
- R4: The clock edge 2^N cycles after the arming write sets the state flag (word A bit 2), and the interrupt output follows the state flag.
- R5: An expiry that finds the state flag already set produces a reset pulse exactly one cycle long and latches the reset-status flag (word A bit 3). The state flag stays set.
- R6: Writing 1 to bit 3 or to bit 2 of word A clears only that flag. Writing 0 to either bit leaves it unchanged.
- R7: A service write (word A with bits 3 and 2 both 1) clears both flags and restarts the expiry counter, so the next expiry falls 2^N cycles after that write.
- R8: While disarmed, the expiry counter is held at zero and no expiry occurs. Re-arming gives a full 2^N period.
- R9: With `ENABLE_ONCE` set, once both keys are 1, writes can no longer clear either key.
- R10: Reads of any offset other than 0x0, 0x4 and 0x8 return 0, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, qualified by busSel |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| wdtIrq | output | 1 | Interrupt, high while the state flag is set |
| wdtRstPulse | output | 1 | One-clock system reset request |

## Verification
A wrong expiry count shows at the ports as an interrupt edge that comes one or more clocks early or late after an arming or service write. The bench compares that edge at its exact cycle. A flag that was cleared wrongly or kept wrongly appears in the next read of word A, and on the interrupt pin within the same cycle. A missed or doubled reset pulse shows one clock after the second expiry. A key that was lost under the lock option appears in the very next read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WORD_W      = 32;
  localparam int OFS_CTRL_A  = 'h0;
  localparam int OFS_CTRL_B  = 'h4;
  localparam int OFS_TIME    = 'h8;
  localparam int BIT_RSTFLAG = 3;
  localparam int BIT_STATE   = 2;
  localparam int BIT_KEY_A   = 1;
  localparam int BIT_KEY_B   = 0;

  typedef struct packed {
    logic run;
    logic restart;
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int INTERVAL_LOG2 = 8,
  parameter int TB_W          = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  wdogStrobe_t     strobe,
  output logic            wrapHit,
  output logic [TB_W-1:0] timebase
);
  localparam logic [INTERVAL_LOG2-1:0] CNT_LAST = '1;
  localparam logic [INTERVAL_LOG2-1:0] CNT_ONE  = 1;
  localparam logic [TB_W-1:0]          TB_ONE   = 1;

  logic [INTERVAL_LOG2-1:0] expiryCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timebase <= '0;
    else       timebase <= timebase + TB_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            expiryCnt <= '0;
    else if (!strobe.run || strobe.restart) expiryCnt <= '0;
    else                                  expiryCnt <= expiryCnt + CNT_ONE;
  end

  assign wrapHit = strobe.run && (expiryCnt == CNT_LAST);

  assert_timebase_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> timebase == $past(timebase) + TB_ONE);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run || strobe.restart) |=> expiryCnt == '0);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int ENABLE_ONCE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] timebase,
  input  logic              wrapHit,
  output wdogStrobe_t       strobe,
  output logic [WORD_W-1:0] busRdata,
  output logic              wdtIrq,
  output logic              wdtRstPulse
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(OFS_CTRL_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(OFS_CTRL_B);
  localparam logic [ADDR_W-1:0] ADR_T = ADDR_W'(OFS_TIME);
  localparam bit ONCE = (ENABLE_ONCE != 0);

  logic keyA, keyB, stateFlag, rstFlag, locked;
  logic wrA, wrB, armed, lockNow, service, expire;

  assign wrA     = busSel && busWe && (busAddr == ADR_A);
  assign wrB     = busSel && busWe && (busAddr == ADR_B);
  assign armed   = keyA && keyB;
  assign lockNow = ONCE && (locked || armed);
  assign service = wrA && busWdata[BIT_RSTFLAG] && busWdata[BIT_STATE];
  assign expire  = wrapHit && !service;

  assign strobe.run     = armed;
  assign strobe.restart = service;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyA        <= 1'b0;
      keyB        <= 1'b0;
      stateFlag   <= 1'b0;
      rstFlag     <= 1'b0;
      locked      <= 1'b0;
      wdtRstPulse <= 1'b0;
    end else begin
      if (wrA && !lockNow) keyA <= busWdata[BIT_KEY_A];
      if (wrB && !lockNow) keyB <= busWdata[BIT_KEY_B];
      locked <= locked || (ONCE && armed);
      if (expire)                        stateFlag <= 1'b1;
      else if (wrA && busWdata[BIT_STATE]) stateFlag <= 1'b0;
      if (expire && stateFlag)             rstFlag <= 1'b1;
      else if (wrA && busWdata[BIT_RSTFLAG]) rstFlag <= 1'b0;
      wdtRstPulse <= expire && stateFlag;
    end
  end

  assign wdtIrq = stateFlag;

  always_comb begin
    busRdata = '0;
    if (busAddr == ADR_A) begin
      busRdata[BIT_RSTFLAG] = rstFlag;
      busRdata[BIT_STATE]   = stateFlag;
      busRdata[BIT_KEY_A]   = keyA;
      busRdata[BIT_KEY_B]   = keyB;
    end else if (busAddr == ADR_B) begin
      busRdata[BIT_KEY_B] = keyB;
    end else if (busAddr == ADR_T) begin
      busRdata = timebase;
    end
  end

  assert_pulse_has_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstPulse |-> (stateFlag && rstFlag));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstPulse |=> !wdtRstPulse);

  assert_state_from_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stateFlag) |-> $past(wrapHit));

  assert_disarmed_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !wdtRstPulse);

  generate
    if (ONCE) begin : gLock
      assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
        locked |=> (keyA && keyB));
    end
  endgenerate
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int INTERVAL_LOG2 = 8,
  parameter int ADDR_W        = 4,
  parameter int ENABLE_ONCE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              wdtIrq,
  output logic              wdtRstPulse
);
  wdogStrobe_t       strobe;
  logic              wrapHit;
  logic [WORD_W-1:0] timebase;

  wdog_datapath #(.INTERVAL_LOG2(INTERVAL_LOG2), .TB_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrapHit(wrapHit), .timebase(timebase)
  );

  wdog_ctrl #(.ADDR_W(ADDR_W), .ENABLE_ONCE(ENABLE_ONCE)) uCtl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .timebase(timebase), .wrapHit(wrapHit), .strobe(strobe),
    .busRdata(busRdata), .wdtIrq(wdtIrq), .wdtRstPulse(wdtRstPulse)
  );
endmodule

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
  localparam int N = 5;
  localparam int PERIOD = 1 << N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] rd0, rd1;
  logic irq0, irq1, pls0, pls1;
  int nChecks = 0, nErr = 0;

  always #4 clk = ~clk;

  wdog_top #(.INTERVAL_LOG2(N), .ADDR_W(4), .ENABLE_ONCE(0)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rd0), .wdtIrq(irq0), .wdtRstPulse(pls0));

  wdog_top #(.INTERVAL_LOG2(N), .ADDR_W(4), .ENABLE_ONCE(1)) u1 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rd1), .wdtIrq(irq1), .wdtRstPulse(pls1));

  // behavioural reference for u0
  logic [31:0] mTb;
  int mCnt;
  bit mKa, mKb, mSt, mRf, mPulse;

  function automatic logic [31:0] mRead(input logic [3:0] a);
    case (a)
      4'h0: return {28'd0, mRf, mSt, mKa, mKb};
      4'h4: return {31'd0, mKb};
      4'h8: return mTb;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTb = 0; mCnt = 0; mKa = 0; mKb = 0; mSt = 0; mRf = 0; mPulse = 0;
    end else begin
      bit wa, wb, on, svc, exp_;
      wa  = busSel && busWe && busAddr == 4'h0;
      wb  = busSel && busWe && busAddr == 4'h4;
      on  = mKa && mKb;
      svc = wa && busWdata[3] && busWdata[2];
      exp_ = on && !svc && (mCnt == PERIOD - 1);
      mPulse = exp_ && mSt;
      if (exp_ && mSt) mRf = 1; else if (wa && busWdata[3]) mRf = 0;
      if (exp_) mSt = 1; else if (wa && busWdata[2]) mSt = 0;
      if (!on || svc) mCnt = 0; else mCnt = (mCnt + 1) % PERIOD;
      if (wa) mKa = busWdata[1];
      if (wb) mKb = busWdata[0];
      mTb = mTb + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_);
    nChecks++;
    if (act !== exp_) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 irq", {31'd0, irq0}, {31'd0, mSt});
      chk("R5 pulse", {31'd0, pls0}, {31'd0, mPulse});
      if (busAddr == 4'h8)      chk("R2 rdata", rd0, mRead(busAddr));
      else if (busAddr == 4'h0 || busAddr == 4'h4) chk("R6 rdata", rd0, mRead(busAddr));
      else                      chk("R10 rdata", rd0, mRead(busAddr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busSel = 0; busWe = 0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp_);
    busAddr = a; #1;
    chk(tag, rd0, exp_);
  endtask

  // after wr(): check irq stays low to edge +PERIOD-1, rises at +PERIOD
  task automatic irqEdge(input string tag);
    repeat (PERIOD - 1) @(posedge clk);
    #3 chk(tag, {31'd0, irq0}, 32'd0);
    @(posedge clk);
    #3 chk(tag, {31'd0, irq0}, 32'd1);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(posedge clk); #3;
    // R1
    rd("R1 wordA", 4'h0, 32'd0);
    rd("R1 wordB", 4'h4, 32'd0);
    chk("R1 irq", {31'd0, irq0}, 32'd0);
    chk("R1 pulse", {31'd0, pls0}, 32'd0);
    // R2
    busAddr = 4'h8; #1 a = rd0;
    @(posedge clk); #3 b = rd0;
    chk("R2 step", b, a + 32'd1);
    // R3: key A alone
    wr(4'h0, 32'h2);
    repeat (3 * PERIOD) @(posedge clk);
    #3 chk("R3 no expiry", {31'd0, irq0}, 32'd0);
    rd("R3 keyA only", 4'h0, 32'h2);
    // R4: arm with key B, first expiry
    wr(4'h4, 32'h1);
    rd("R3 mirror", 4'h0, 32'h3);
    irqEdge("R4 first expiry");
    rd("R4 state flag", 4'h0, 32'h7);
    // R5: second expiry
    repeat (PERIOD - 1) @(posedge clk);
    #3 chk("R5 no early pulse", {31'd0, pls0}, 32'd0);
    @(posedge clk);
    #3 chk("R5 pulse", {31'd0, pls0}, 32'd1);
    rd("R5 flags", 4'h0, 32'hF);
    @(posedge clk);
    #3 chk("R5 one cycle", {31'd0, pls0}, 32'd0);
    // R6: single-bit clears
    wr(4'h0, 32'hA);
    rd("R6 clear rst flag", 4'h0, 32'h7);
    wr(4'h0, 32'h6);
    rd("R6 clear state", 4'h0, 32'h3);
    chk("R6 irq low", {31'd0, irq0}, 32'd0);
    // R7: service restarts period
    wr(4'h0, 32'hE);
    rd("R7 after service", 4'h0, 32'h3);
    irqEdge("R7 period after service");
    // R8: disarm holds, rearm restarts
    wr(4'h0, 32'hE);
    wr(4'h4, 32'h0);
    repeat (4 * PERIOD) @(posedge clk);
    #3 chk("R8 idle irq", {31'd0, irq0}, 32'd0);
    rd("R8 idle word", 4'h0, 32'h2);
    wr(4'h4, 32'h1);
    irqEdge("R8 rearm period");
    // R9: lock option on u1
    wr(4'h0, 32'hC);
    rd("R9 unlocked clears", 4'h0, 32'h1);
    chk("R9 locked keys", {30'd0, rd1[1:0]}, 32'h3);
    wr(4'h4, 32'h0);
    busAddr = 4'h4; #1;
    chk("R9 locked keyB", rd1, 32'h1);
    chk("R9 unlocked keyB", rd0, 32'h0);
    // R10: unmapped offsets
    wr(4'hC, 32'hFFFF_FFFF);
    rd("R10 read C", 4'hC, 32'd0);
    rd("R10 wordA intact", 4'h0, 32'h0);
    wr(4'h1, 32'hFFFF_FFFF);
    rd("R10 read 1", 4'h1, 32'd0);
    rd("R10 wordB intact", 4'h4, 32'h0);
    repeat (4) @(posedge clk);
    #3 finishRun();
  end
endmodule